// File: doc/BRIEF.md
# Boundary-Scan Identity Probe

This block is a host-side test-port master for one target device. On a start pulse it produces the test clock, mode select and data-in lines that take the target's test access port through a full identity read. The sequence has five parts: a forced reset, a short park in the idle state, loading a 5-bit instruction through the instruction path, a 32-bit scan of the selected data register, and a return to idle. The serial data-out line is sampled while the data register is scanned.

After the last clock the captured word is compared in hardware with an expected identity supplied on a port. The result appears on `done`, `pass` and `capturedId` and stays there until the next start. A mismatch means the scan chain is broken, a wrong part is fitted, or the instruction did not load. The test clock is a divided copy of the system clock. A divider input sets the half period.

Top module: `tapIdProbe`

## Requirements
- R1: After reset, `tck`, `tms`, `tdi`, `done` and `pass` are 0 and `capturedId` is all zeros.
- R2: A run opens with RESET_LEN (5) test clocks with `tms`=1, then IDLE_LEN (4) clocks with `tms`=0. This puts the target in Run-Test/Idle from any starting state.
- R3: The instruction walk uses `tms` 1,1,0,0. It then sends IR_CODE (default 5'b01100) on `tdi`, least significant bit first, with `tms` at 0 for the first four bits and 1 on the fifth. It ends with one `tms`=1 clock (update) and IDLE_LEN clocks with `tms`=0. `tdi` is 1 only while an instruction bit is being sent.
- R4: The data walk uses `tms` 1,0,0, then 32 scan clocks with `tms`=1 only on the last one, then one `tms`=1 clock (update) and IDLE_LEN idle clocks. A run has 63 test clocks in total and leaves the target in Run-Test/Idle.
- R5: Each `tck` high and low phase lasts `divLimit`+1 system clocks. `tck` rests at 0 when no run is in progress.
- R6: `tms` and `tdi` change only as `tck` falls, never while it is high. `tdo` is sampled as `tck` rises, and the first bit sampled becomes bit 0 of `capturedId`.
- R7: When the run ends, `done` rises, and `pass` is 1 exactly when `capturedId` equals `expectId` as presented at that moment.
- R8: A start pulse clears `done` and `pass`. After completion, `done`, `pass` and `capturedId` keep their values until the next start, whatever `expectId` and `tdo` do.
- R9: A start pulse during a run is ignored: the run keeps its 63-clock sequence and its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin an identity read |
| divLimit | input | DIV_W | Half period of `tck` in system clocks, minus one |
| expectId | input | ID_W | Identity the target should return |
| tdo | input | 1 | Serial data from the target |
| tck | output | 1 | Test clock to the target |
| tms | output | 1 | Mode select to the target |
| tdi | output | 1 | Serial data to the target |
| done | output | 1 | Run finished; held until next start |
| pass | output | 1 | Captured identity matched the expected value |
| capturedId | output | ID_W | Identity word shifted out of the target |

## Verification
The target is a behavioural port model that follows all sixteen controller states. Each run starts this model in a random state, so the reset prefix must work from anywhere. The model only returns its identity if the instruction was loaded correctly, so a wrong code or bit order shows up as a bad capture. Matching and single-bit-mismatch expectations separate compare errors from capture errors: the all-ones word with bit 31 flipped tests the final bit, and a zero identity tests a stuck line. Random divider values and a start pulse in mid-run test clock pacing, the edge on which outputs change, and the rule that a busy probe ignores a new start.

// File: rtl/tapProbePkg.sv
package tapProbePkg;

  typedef struct packed {
    logic clear;     // start accepted: reload instruction, clear results
    logic irWin;     // an instruction bit is on the serial line
    logic irShift;   // falling tck closing an instruction bit
    logic drSample;  // rising tck inside the identity scan
    logic finish;    // falling tck closing the last step
  } probeStrobe_t;

endpackage

// File: rtl/tapProbeCtrl.sv
module tapProbeCtrl
  import tapProbePkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int IR_LEN    = 5,
  parameter int ID_W      = 32,
  parameter int IDLE_LEN  = 4,
  parameter int RESET_LEN = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DIV_W-1:0] divLimit,
  output logic             tck,
  output logic             tms,
  output probeStrobe_t     stb
);

  localparam int S_IDL1 = RESET_LEN;
  localparam int S_TOIR = S_IDL1 + IDLE_LEN;
  localparam int S_IR   = S_TOIR + 4;
  localparam int S_UIR  = S_IR + IR_LEN;
  localparam int S_IDL2 = S_UIR + 1;
  localparam int S_TODR = S_IDL2 + IDLE_LEN;
  localparam int S_DR   = S_TODR + 3;
  localparam int S_UDR  = S_DR + ID_W;
  localparam int S_IDL3 = S_UDR + 1;
  localparam int S_END  = S_IDL3 + IDLE_LEN;
  localparam int STEP_W = $clog2(S_END + 1);

  logic              running;
  logic              tckR;
  logic [DIV_W-1:0]  divCnt;
  logic [STEP_W-1:0] stepIdx;
  logic              tick;
  int                stepNum;

  function automatic logic tmsOf(input int s);
    if (s < S_IDL1)      return 1'b1;
    else if (s < S_TOIR) return 1'b0;
    else if (s < S_IR)   return (s < S_TOIR + 2);
    else if (s < S_UIR)  return (s == S_UIR - 1);
    else if (s < S_IDL2) return 1'b1;
    else if (s < S_TODR) return 1'b0;
    else if (s < S_DR)   return (s == S_TODR);
    else if (s < S_UDR)  return (s == S_UDR - 1);
    else if (s < S_IDL3) return 1'b1;
    else                 return 1'b0;
  endfunction

  assign stepNum = int'(stepIdx);
  assign tick    = running && (divCnt >= divLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      tckR    <= 1'b0;
      divCnt  <= '0;
      stepIdx <= '0;
    end else if (!running) begin
      if (start) begin
        running <= 1'b1;
        stepIdx <= '0;
        divCnt  <= '0;
      end
    end else if (tick) begin
      divCnt <= '0;
      tckR   <= ~tckR;
      if (tckR) begin
        if (stepNum == S_END - 1) running <= 1'b0;
        else                      stepIdx <= stepIdx + 1'b1;
      end
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_comb begin
    stb.clear    = !running && start;
    stb.irWin    = running && (stepNum >= S_IR) && (stepNum < S_UIR);
    stb.irShift  = tick && tckR && stb.irWin;
    stb.drSample = tick && !tckR && (stepNum >= S_DR) && (stepNum < S_UDR);
    stb.finish   = tick && tckR && (stepNum == S_END - 1);
  end

  assign tck = tckR;
  assign tms = running && tmsOf(stepNum);

  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    stepNum < S_END);  // R4
  AST_TCK_PARKED: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !tckR);  // R5
  AST_TMS_HELD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    tckR |-> $stable(tms));  // R6
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rstN)
    running && start && !tick |=> $stable(stepIdx));  // R9

endmodule

// File: rtl/tapProbeData.sv
module tapProbeData
  import tapProbePkg::*;
#(
  parameter int                IR_LEN  = 5,
  parameter int                ID_W    = 32,
  parameter logic [IR_LEN-1:0] IR_CODE = 5'b01100
) (
  input  logic            clk,
  input  logic            rstN,
  input  probeStrobe_t    stb,
  input  logic            tdo,
  input  logic [ID_W-1:0] expectId,
  output logic            tdi,
  output logic            done,
  output logic            pass,
  output logic [ID_W-1:0] capturedId
);

  logic [IR_LEN-1:0] irSr;
  logic [ID_W-1:0]   idSr;
  logic              doneR;
  logic              passR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irSr  <= '0;
      idSr  <= '0;
      doneR <= 1'b0;
      passR <= 1'b0;
    end else if (stb.clear) begin
      irSr  <= IR_CODE;
      idSr  <= '0;
      doneR <= 1'b0;
      passR <= 1'b0;
    end else begin
      if (stb.irShift)  irSr <= {1'b0, irSr[IR_LEN-1:1]};
      if (stb.drSample) idSr <= {tdo, idSr[ID_W-1:1]};
      if (stb.finish) begin
        doneR <= 1'b1;
        passR <= (idSr == expectId);
      end
    end
  end

  assign tdi        = stb.irWin & irSr[0];
  assign done       = doneR;
  assign pass       = passR;
  assign capturedId = idSr;

  AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    passR |-> doneR);  // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    doneR && !stb.clear |=> doneR && $stable(idSr) && $stable(passR));  // R8
  AST_NO_SCAN_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    doneR |-> !stb.drSample && !stb.irShift);  // R8

endmodule

// File: rtl/tapIdProbe.sv
module tapIdProbe
  import tapProbePkg::*;
#(
  parameter int                DIV_W     = 8,
  parameter int                ID_W      = 32,
  parameter int                IR_LEN    = 5,
  parameter logic [IR_LEN-1:0] IR_CODE   = 5'b01100,
  parameter int                IDLE_LEN  = 4,
  parameter int                RESET_LEN = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DIV_W-1:0] divLimit,
  input  logic [ID_W-1:0]  expectId,
  input  logic             tdo,
  output logic             tck,
  output logic             tms,
  output logic             tdi,
  output logic             done,
  output logic             pass,
  output logic [ID_W-1:0]  capturedId
);

  probeStrobe_t stb;

  tapProbeCtrl #(
    .DIV_W(DIV_W), .IR_LEN(IR_LEN), .ID_W(ID_W),
    .IDLE_LEN(IDLE_LEN), .RESET_LEN(RESET_LEN)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .divLimit(divLimit),
    .tck(tck), .tms(tms), .stb(stb)
  );

  tapProbeData #(
    .IR_LEN(IR_LEN), .ID_W(ID_W), .IR_CODE(IR_CODE)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .tdo(tdo), .expectId(expectId),
    .tdi(tdi), .done(done), .pass(pass), .capturedId(capturedId)
  );

endmodule

// File: tb/sim_tapIdProbe.sv
module sim_tapIdProbe;

  localparam int          TOTAL_TCK = 63;
  localparam logic [4:0]  CODE      = 5'b01100;
  localparam int TLR = 0, RTI = 1, SELDR = 2, CAPDR = 3, SHDR = 4, EX1DR = 5,
                 PSDR = 6, EX2DR = 7, UPDR = 8, SELIR = 9, CAPIR = 10,
                 SHIR = 11, EX1IR = 12, PSIR = 13, EX2IR = 14, UPIR = 15;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  divLimit = 8'd0;
  logic [31:0] expectId = '0;
  logic        tdo = 1'b0;
  logic        tck, tms, tdi, done, pass;
  logic [31:0] capturedId;

  tapIdProbe u0 (
    .clk(clk), .rstN(rstN), .start(start), .divLimit(divLimit),
    .expectId(expectId), .tdo(tdo), .tck(tck), .tms(tms), .tdi(tdi),
    .done(done), .pass(pass), .capturedId(capturedId)
  );

  always #2 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  // behavioural target port
  int          tapSt = TLR;
  logic [4:0]  irReg = 5'b11111;
  logic [4:0]  irSh = '0;
  logic [31:0] drSh = '0;
  logic [31:0] targetId = '0;
  int          riseCnt = 0;
  int          tdiStray = 0;

  function automatic int nextSt(input int s, input logic m);
    case (s)
      TLR:   return m ? TLR   : RTI;
      RTI:   return m ? SELDR : RTI;
      SELDR: return m ? SELIR : CAPDR;
      CAPDR: return m ? EX1DR : SHDR;
      SHDR:  return m ? EX1DR : SHDR;
      EX1DR: return m ? UPDR  : PSDR;
      PSDR:  return m ? EX2DR : PSDR;
      EX2DR: return m ? UPDR  : SHDR;
      UPDR:  return m ? SELDR : RTI;
      SELIR: return m ? TLR   : CAPIR;
      CAPIR: return m ? EX1IR : SHIR;
      SHIR:  return m ? EX1IR : SHIR;
      EX1IR: return m ? UPIR  : PSIR;
      PSIR:  return m ? EX2IR : PSIR;
      EX2IR: return m ? UPIR  : SHIR;
      default: return m ? SELDR : RTI;
    endcase
  endfunction

  always @(posedge tck) begin
    riseCnt = riseCnt + 1;
    if (tdi && tapSt != SHIR) tdiStray = tdiStray + 1;
    case (tapSt)
      TLR:   irReg = 5'b11111;
      CAPIR: irSh = 5'b00001;
      SHIR:  irSh = {tdi, irSh[4:1]};
      UPIR:  irReg = irSh;
      CAPDR: drSh = (irReg == CODE) ? targetId : 32'h0;
      SHDR:  drSh = {tdi, drSh[31:1]};
      default: ;
    endcase
    tapSt = nextSt(tapSt, tms);
  end

  always @(negedge tck) begin
    if (tapSt == SHDR)      tdo = drSh[0];
    else if (tapSt == SHIR) tdo = irSh[0];
    else                    tdo = 1'b0;
  end

  // edge and period monitor, sampled away from the active edge
  logic prevTck = 1'b0, prevTms = 1'b0, prevTdi = 1'b0;
  int   lastRise = -1;
  int   edgeViol = 0;
  int   periodBad = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (tck && (tms != prevTms || tdi != prevTdi)) edgeViol = edgeViol + 1;
    if (tck && !prevTck) begin
      if (lastRise >= 0 && (cyc - lastRise) != 2 * (int'(divLimit) + 1))
        periodBad = periodBad + 1;
      lastRise = cyc;
    end
    prevTck = tck; prevTms = tms; prevTdi = tdi;
    if (cyc == 150000) begin
      tests = tests + 1; fails = fails + 1;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit expPass(input logic [31:0] id, input logic [31:0] ex);
    return id == ex;
  endfunction

  task automatic runOne(input logic [31:0] id, input logic [31:0] ex,
                        input logic [7:0] dv, input int initSt, input bit midStart);
    int waitCnt;
    targetId = id; expectId = ex; divLimit = dv;
    tapSt = initSt; irReg = 5'b11111;
    riseCnt = 0; tdiStray = 0; edgeViol = 0; periodBad = 0; lastRise = -1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(done == 1'b0 && pass == 1'b0, "R8 start clears done", {30'd0, done, pass}, 32'd0);
    if (midStart) begin
      repeat (40) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    waitCnt = 0;
    while (!done && waitCnt < 20000) begin
      @(negedge clk); waitCnt = waitCnt + 1;
    end
    check(done == 1'b1, "R7 done rises", {31'd0, done}, 32'd1);
    check(capturedId == id, "R6 rising-edge capture", capturedId, id);
    check(pass == expPass(id, ex), "R7 compare", {31'd0, pass}, {31'd0, expPass(id, ex)});
    check(riseCnt == TOTAL_TCK, midStart ? "R9 busy start ignored" : "R4 clock count",
          riseCnt, TOTAL_TCK);
    check(tapSt == RTI, "R4 ends in idle", tapSt, RTI);
    check(irReg == CODE, "R3 instruction loaded", {27'd0, irReg}, {27'd0, CODE});
    check(tdiStray == 0, "R3 tdi quiet outside instruction", tdiStray, 0);
    check(edgeViol == 0, "R6 tms/tdi change on falling edge", edgeViol, 0);
    check(periodBad == 0, "R5 tck half period", periodBad, 0);
    check(tck == 1'b0, "R5 tck parked low", {31'd0, tck}, 32'd0);
    // hold: disturb inputs and confirm results stay
    expectId = ~ex; tdo = ~tdo;
    repeat (30) @(negedge clk);
    check(done && pass == expPass(id, ex) && capturedId == id, "R8 results held",
          capturedId, id);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check(tck == 0 && tms == 0 && tdi == 0 && done == 0 && pass == 0 && capturedId == 0,
          "R1 reset state", capturedId, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // directed corners
    runOne(32'h1234_5677, 32'h1234_5677, 8'd0, TLR, 1'b0);   // R2 from reset state
    runOne(32'hFFFF_FFFF, 32'h7FFF_FFFF, 8'd1, SHDR, 1'b0);  // R7 top bit mismatch
    runOne(32'h0000_0000, 32'h0000_0000, 8'd2, PSIR, 1'b0);  // R2 from pause state
    runOne(32'hA5C3_0F01, 32'hA5C3_0F01, 8'd3, EX2DR, 1'b1); // R9 start while busy
    // random runs
    for (int k = 0; k < 8; k++) begin
      logic [31:0] id;
      logic [31:0] ex;
      id = $urandom();
      ex = ($urandom() % 2 == 0) ? id : (id ^ (32'd1 << ($urandom() % 32)));
      runOne(id, ex, 8'($urandom() % 4), int'($urandom() % 16), ($urandom() % 4) == 0);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule